// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block turns a bank of general-purpose input pins into interrupt events. Each pin passes through a synchronizer. Software then picks one of three sensing styles for that pin. Level sensing reports the pin while it sits at the chosen level. Single-edge sensing catches a rising or a falling transition. Both-edge sensing catches any transition.

Edge events are held in a sticky status bit until software clears them through a write-one-to-clear register. Level events are never held: they follow the synchronized pin and vanish when the level goes away. A per-pin enable masks the raw status into a masked status. The OR of all masked bits drives one combined interrupt line.

Software reaches the block through a small register file. There is a write port and a combinational read port, each with a 3-bit register index. The write port has a one-cycle strobe. The register map is: 0 sense select, 1 both-edge select, 2 polarity, 3 enable, 4 raw status, 5 masked status, 6 clear. Index 7 is unused and reads as zero.

Top module: `gpioirq_detector`

## Requirements
- R1: With sense bit = 1 (index 0) a pin is level sensed. Its raw status bit (index 4) is 1 while the synchronized pin equals its polarity bit (index 2; 1 = high, 0 = low). The bit drops as soon as the pin leaves that level, with no clear needed.
- R2: With sense bit = 0 and both-edge bit = 0 (index 1), polarity 1 latches a rising edge and polarity 0 latches a falling edge. The raw bit stays 1 after the pin returns to its old level.
- R3: With sense bit = 0 and both-edge bit = 1, any transition of the pin latches the raw bit, whatever the polarity bit holds.
- R4: Writing the clear register (index 6) clears each latched edge bit whose write-data bit is 1. Bits written 0 are untouched.
- R5: If a clear of a pin and a new qualifying edge on that pin fall in the same cycle, the raw bit ends up 1.
- R6: The masked status (index 5) equals raw status AND enable (index 3). An enable bit of 0 removes the pin from the masked status.
- R7: The interrupt output is 1 exactly when some masked status bit is 1.
- R8: The clear register reads 0. Writes to the raw and masked status indices change nothing.
- R9: After reset, sense, both-edge, polarity and enable read 0, and no edge event is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPINS | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | NPINS | Write data, one bit per pin |
| rd_addr | input | 3 | Register index for the read |
| rd_data | output | NPINS | Read data for rd_addr |
| irq_out | output | 1 | Combined interrupt |

## Verification
The assertions check several properties on every cycle: a latched edge bit stays set unless a clear names it, a level-sensed pin never latches, the interrupt needs some enable, the clear index reads zero, masked reads stay inside the enable, and configuration is zero after reset. Only the bench scenarios can show the rest. These are the sweep over every pin and every sensing style, the polarity being ignored under both-edge sensing, the edge winning over a same-cycle clear, and status writes being ignored.

// File: rtl/gpioirq_pkg.sv
package gpioirq_pkg;
   localparam int ADDR_W = 3;
   typedef enum logic [ADDR_W-1:0] {
      A_SENSE = 3'd0,
      A_DUAL  = 3'd1,
      A_POL   = 3'd2,
      A_EN    = 3'd3,
      A_RAW   = 3'd4,
      A_MSK   = 3'd5,
      A_CLR   = 3'd6,
      A_RSVD  = 3'd7
   } reg_idx_e;
endpackage

// File: rtl/gpioirq_sync.sv
module gpioirq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   initial begin
      if (STAGES < 2) $error("gpioirq_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= din;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpioirq_cfg.sv
module gpioirq_cfg
   import gpioirq_pkg::*;
#(
   parameter int NPINS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [NPINS-1:0]  wr_data,
   output logic [NPINS-1:0]  sense_q,
   output logic [NPINS-1:0]  dual_q,
   output logic [NPINS-1:0]  pol_q,
   output logic [NPINS-1:0]  en_q,
   output logic [NPINS-1:0]  clr_pulse
);
   logic hit_sense, hit_dual, hit_pol, hit_en, hit_clr;

   always_comb begin
      hit_sense = wr_en && (wr_addr == A_SENSE);
      hit_dual  = wr_en && (wr_addr == A_DUAL);
      hit_pol   = wr_en && (wr_addr == A_POL);
      hit_en    = wr_en && (wr_addr == A_EN);
      hit_clr   = wr_en && (wr_addr == A_CLR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         dual_q  <= '0;
         pol_q   <= '0;
         en_q    <= '0;
      end else begin
         if (hit_sense) sense_q <= wr_data;
         if (hit_dual)  dual_q  <= wr_data;
         if (hit_pol)   pol_q   <= wr_data;
         if (hit_en)    en_q    <= wr_data;
      end
   end

   assign clr_pulse = hit_clr ? wr_data : '0;
endmodule

// File: rtl/gpioirq_lane.sv
module gpioirq_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic smp,
   input  logic sense,
   input  logic dual,
   input  logic pol,
   input  logic clr,
   output logic latch_q,
   output logic raw
);
   logic prev_q;
   logic rise, fall, edge_hit, level_hit;

   always_comb begin
      rise      = smp & ~prev_q;
      fall      = ~smp & prev_q;
      edge_hit  = ~sense & (dual ? (rise | fall) : (pol ? rise : fall));
      level_hit = (smp == pol);
      raw       = sense ? level_hit : latch_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q  <= smp;
         latch_q <= (latch_q & ~clr) | edge_hit;
      end
   end
endmodule

// File: rtl/gpioirq_detector.sv
module gpioirq_detector
   import gpioirq_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [NPINS-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [NPINS-1:0]  rd_data,
   output logic              irq_out
);
   initial begin
      if (NPINS < 1 || NPINS > 32) $error("gpioirq_detector: NPINS out of range");
   end

   logic [NPINS-1:0] smp;
   logic [NPINS-1:0] sense_q, dual_q, pol_q, en_q, clr_pulse;
   logic [NPINS-1:0] lat_q, raw_st, msk_st;

   gpioirq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(smp)
   );

   gpioirq_cfg #(.NPINS(NPINS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sense_q(sense_q), .dual_q(dual_q),
      .pol_q(pol_q), .en_q(en_q), .clr_pulse(clr_pulse)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_lane
      gpioirq_lane u_lane (
         .clk(clk), .rst_n(rst_n), .smp(smp[i]), .sense(sense_q[i]),
         .dual(dual_q[i]), .pol(pol_q[i]), .clr(clr_pulse[i]),
         .latch_q(lat_q[i]), .raw(raw_st[i])
      );
   end

   assign msk_st  = raw_st & en_q;
   assign irq_out = |msk_st;

   always_comb begin
      case (rd_addr)
         A_SENSE: rd_data = sense_q;
         A_DUAL:  rd_data = dual_q;
         A_POL:   rd_data = pol_q;
         A_EN:    rd_data = en_q;
         A_RAW:   rd_data = raw_st;
         A_MSK:   rd_data = msk_st;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpioirq_checker.sv
module gpioirq_checker
   import gpioirq_pkg::*;
#(
   parameter int NPINS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [NPINS-1:0]  wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [NPINS-1:0]  rd_data,
   input logic              irq_out,
   input logic [NPINS-1:0]  sense_q,
   input logic [NPINS-1:0]  en_q,
   input logic [NPINS-1:0]  lat_q
);
   a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (en_q != '0));

   a_r8_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == A_CLR) |-> (rd_data == '0));

   a_r6_masked_in_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == A_MSK) |-> ((rd_data & ~en_q) == '0));

   a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (sense_q == '0 && en_q == '0 && lat_q == '0));

   for (genvar i = 0; i < NPINS; i++) begin : g_bit
      a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (lat_q[i] && !(wr_en && wr_addr == A_CLR && wr_data[i])) |=> lat_q[i]);

      a_r1_level_not_latched: assert property (@(posedge clk) disable iff (!rst_n)
         (!lat_q[i] && sense_q[i]) |=> !lat_q[i]);
   end
endmodule

bind gpioirq_detector gpioirq_checker #(.NPINS(NPINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
   .irq_out(irq_out), .sense_q(sense_q), .en_q(en_q), .lat_q(lat_q)
);

// File: tb/gpioirq_detector_bench.sv
module gpioirq_detector_bench;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin_in = '0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [N-1:0] wr_data = '0;
   logic [2:0]   rd_addr = '0;
   logic [N-1:0] rd_data;
   logic         irq_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   gpioirq_detector #(.NPINS(N), .SYNC_STAGES(2)) u_gpioirq_detector (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic expect_bit(input string tag, input int p, input bit e);
      logic [N-1:0] v;
      logic [N-1:0] ex;
      ex = e ? (N'(1) << p) : '0;
      rd(3'd4, v); chk({tag, " raw"}, 32'(v), 32'(ex));
      rd(3'd5, v); chk({tag, " R6 masked"}, 32'(v), 32'(ex));
      chk({tag, " R7 irq"}, 32'(irq_out), 32'(e));
   endtask

   initial begin
      logic [N-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         chk($sformatf("R9 reset idx %0d", a), 32'(v), 32'h0);
      end
      chk("R9 reset irq", 32'(irq_out), 32'h0);

      // Sweep: every pin, every sensing style
      for (int p = 0; p < N; p++) begin
         for (int m = 0; m < 6; m++) begin
            bit lvl, pol, dual, lat, cur, e;
            string tag;
            lvl  = (m < 2);
            pol  = (m == 0) || (m == 2) || (m == 5);
            dual = (m >= 4);
            tag  = lvl ? "R1" : (dual ? "R3" : "R2");
            tag  = $sformatf("%s pin%0d mode%0d", tag, p, m);
            wr(3'd0, lvl  ? (N'(1) << p) : '0);
            wr(3'd1, dual ? (N'(1) << p) : '0);
            wr(3'd2, pol  ? (N'(1) << p) : '0);
            wr(3'd3, N'(1) << p);
            wr(3'd6, '1);
            settle();
            lat = 0; cur = 0;
            e = lvl ? (cur == pol) : lat;
            expect_bit({tag, " idle"}, p, e);
            pin_in[p] = 1'b1; cur = 1; settle();
            if (!lvl && (dual || pol)) lat = 1;
            e = lvl ? (cur == pol) : lat;
            expect_bit({tag, " after rise"}, p, e);
            pin_in[p] = 1'b0; cur = 0; settle();
            if (!lvl && (dual || !pol)) lat = 1;
            e = lvl ? (cur == pol) : lat;
            expect_bit({tag, " after fall"}, p, e);
            wr(3'd6, N'(1) << p); lat = 0; settle();
            e = lvl ? (cur == pol) : lat;
            expect_bit({tag, " R4 after clear"}, p, e);
         end
      end

      // R6: enable 0 masks a level-high pin
      wr(3'd0, 8'h08); wr(3'd1, 8'h00); wr(3'd2, 8'h08); wr(3'd3, 8'h00);
      wr(3'd6, 8'hFF);
      pin_in[3] = 1'b1; settle();
      rd(3'd4, v); chk("R6 raw with enable off", 32'(v), 32'h08);
      rd(3'd5, v); chk("R6 masked with enable off", 32'(v), 32'h00);
      chk("R7 irq with enable off", 32'(irq_out), 32'h0);
      // R4: clearing a level pin does not drop it
      wr(3'd6, 8'hFF); settle();
      rd(3'd4, v); chk("R4 clear ignored for level", 32'(v), 32'h08);
      pin_in[3] = 1'b0; settle();
      rd(3'd4, v); chk("R1 level drops", 32'(v), 32'h00);

      // R4: writing 0 bits leaves a latched edge alone
      wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h20); wr(3'd3, 8'h20);
      wr(3'd6, 8'hFF); settle();
      pin_in[5] = 1'b1; settle();
      wr(3'd6, 8'hDF); settle();
      rd(3'd4, v); chk("R4 zero bits no effect", 32'(v), 32'h20);
      // R8: status writes ignored, clear reads 0
      wr(3'd4, 8'h00); wr(3'd5, 8'h00); settle();
      rd(3'd4, v); chk("R8 raw write ignored", 32'(v), 32'h20);
      rd(3'd6, v); chk("R8 clear reads zero", 32'(v), 32'h00);
      wr(3'd6, 8'h20); settle();
      pin_in[5] = 1'b0; settle();

      // R5: clear and new edge in the same cycle (both-edge pin 0)
      wr(3'd0, 8'h00); wr(3'd1, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h01);
      wr(3'd6, 8'hFF); settle();
      pin_in[0] = 1'b1; settle();
      rd(3'd4, v); chk("R5 setup latched", 32'(v), 32'h01);
      @(negedge clk);
      pin_in[0] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd6; wr_data = 8'h01;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      settle();
      rd(3'd4, v); chk("R5 edge wins over clear", 32'(v), 32'h01);
      wr(3'd6, 8'h01); settle();
      rd(3'd4, v); chk("R4 plain clear", 32'(v), 32'h00);
      chk("R7 irq low after clear", 32'(irq_out), 32'h0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog act=hung exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule